// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a two-wire serial memory front end. It gathers the data bytes of one write transaction into a page-wide latch and keeps the starting address with them. When the transaction closes correctly, it decides whether the latched bytes may be committed to the storage array. The front end supplies single-cycle strobes: a START seen on the bus, the loading of a word address, each accepted data byte, and a STOP. A qualifier flag on the STOP strobe tells whether the STOP arrived in the clock that directly follows a data acknowledge.

A commit raises `busy` for a write cycle whose length is a parameter in system clocks. During the first clocks of that cycle the block scans the latch and sends each written entry to the array write port, one entry per clock. While `busy` is high the block ignores every bus-side strobe. If the write-protect input is high and the page lies in the top quarter of the array, the transaction is dropped without a write cycle, and the block is ready again on the next clock.

Top module: `pgwr_commit`

## Requirements
- R1: After reset `busy` and `mem_we` are 0.
- R2: Each accepted data byte goes to column `addr[4:0]` of the page `addr[12:5]` loaded by `addr_load`. The column then advances by one, so byte k of a transaction is committed to word address `{page, col+k}`.
- R3: The column counter is 5 bits wide and wraps inside the page. Byte 33 lands on the same column as byte 1 and replaces it, and bytes past column 31 go to columns 0, 1, ... of the same page.
- R4: A commit writes only the columns that received a byte. It issues one `mem_we` pulse per written column, in ascending column order, with `mem_addr = {page, column}` and `mem_wdata` equal to the last byte stored there. A transaction with a single data byte gives exactly one write.
- R5: A write cycle starts only on `stop_stb` with `stop_ok=1`. A `stop_stb` with `stop_ok=0` discards the latched bytes, so a later qualified STOP with no new bytes starts nothing.
- R6: With `wp=1` and the page in the top quarter (word addresses 0x1800 to 0x1FFF), a qualified STOP starts no write cycle, issues no writes, discards the bytes and leaves `busy` at 0. Address 0x17FF is still writable.
- R7: With `wp=0`, every address, including 0x1800 to 0x1FFF, is committed.
- R8: After a committing STOP, `busy` is 1 for exactly `WRITE_CYCLES` clocks, starting from the clock edge that samples the strobe.
- R9: While `busy` is 1, `start_stb`, `addr_load`, `byte_stb` and `stop_stb` have no effect. This holds on the last busy clock as well.
- R10: `start_stb` clears all latched bytes. A qualified STOP with no byte latched since the last START or discard starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_stb | input | 1 | START condition detected |
| addr_load | input | 1 | Load the word address from `addr_in` |
| addr_in | input | 13 | Word address from the front end |
| byte_stb | input | 1 | Data byte accepted and acknowledged |
| byte_data | input | 8 | Data byte value |
| stop_stb | input | 1 | STOP condition detected |
| stop_ok | input | 1 | STOP fell in the clock right after a data ACK |
| wp | input | 1 | Write-protect pin level |
| busy | output | 1 | Write cycle in progress; bus strobes are ignored |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The collision that matters is a bus strobe arriving in the last clock of the write cycle, while the cycle timer is ending. That strobe must still be ignored, because the block is not yet idle. The bench provokes this by holding an address load, a data byte and a qualified STOP on every clock during `busy`, and releasing them only once it sees `busy` low. The case is judged by the count of array writes, which must stay at one, and by `busy`, which must stay low for a full write-cycle length afterwards. Write order and data are judged against the ascending-column rule, using wrapped and overwritten columns.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  // Write protection covers the top quarter of the array: the two
  // most significant page bits both set, while the protect pin is high.
  function automatic logic upper_quarter_locked(input logic [1:0] page_top2,
                                                input logic wp_level);
    return wp_level && (page_top2 == 2'b11);
  endfunction
endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int COL_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - COL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  load_en,
  input  logic [ADDR_W-1:0]     load_addr,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [COL_W-1:0]      rd_idx,
  output logic [DATA_W-1:0]     rd_data,
  output logic [PAGE_BYTES-1:0] valid_vec,
  output logic [PAGE_W-1:0]     page,
  output logic                  any_valid
);
  logic [DATA_W-1:0] store [PAGE_BYTES];
  logic [COL_W-1:0]  col;

  // Storage has no reset and a registered read, so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) store[col] <= wr_data;
    rd_data <= store[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col  <= '0;
      page <= '0;
    end else if (load_en) begin
      col  <= load_addr[COL_W-1:0];
      page <= load_addr[ADDR_W-1:COL_W];
    end else if (wr_en) begin
      col  <= col + 1'b1;  // wraps inside the page
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
    end else begin
      if (clear) valid_vec <= '0;
      if (wr_en) valid_vec[col] <= 1'b1;
    end
  end

  assign any_valid = |valid_vec;
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int WRITE_CYCLES = 500000,
  parameter int PAGE_BYTES   = 32,
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1),
  localparam int COL_W       = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  output logic             busy,
  output logic             done,
  output logic             scan_active,
  output logic [COL_W-1:0] scan_idx
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done        = busy && (cnt == CNT_W'(WRITE_CYCLES - 1));
  assign scan_active = busy && (cnt < CNT_W'(PAGE_BYTES));
  assign scan_idx    = cnt[COL_W-1:0];

  // R8: the write cycle never outlasts its programmed length
  p_busy_bounded_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CNT_W'(WRITE_CYCLES)));

  // R8: a new cycle always begins from a zero count
  p_busy_from_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cnt == '0));
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 500000,
  localparam int COL_W       = $clog2(PAGE_BYTES),
  localparam int PAGE_W      = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_stb,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_stb,
  input  logic              stop_ok,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic                  accept, start_acc, stop_acc, locked;
  logic                  commit_go, latch_clear, cycle_done;
  logic                  scan_active, any_valid;
  logic [COL_W-1:0]      scan_idx;
  logic [PAGE_BYTES-1:0] valid_vec;
  logic [PAGE_W-1:0]     page;

  // All bus-side strobes are gated off during the write cycle.
  assign accept      = !busy;
  assign start_acc   = start_stb && accept;
  assign stop_acc    = stop_stb && accept;
  assign locked      = upper_quarter_locked(page[PAGE_W-1 -: 2], wp);
  assign commit_go   = stop_acc && stop_ok && any_valid && !locked;
  assign latch_clear = start_acc || (stop_acc && !commit_go) || cycle_done;

  pgwr_latch #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)
  ) u_latch (
    .clk       (clk),
    .rst       (rst),
    .clear     (latch_clear),
    .load_en   (addr_load && accept),
    .load_addr (addr_in),
    .wr_en     (byte_stb && accept),
    .wr_data   (byte_data),
    .rd_idx    (scan_idx),
    .rd_data   (mem_wdata),
    .valid_vec (valid_vec),
    .page      (page),
    .any_valid (any_valid)
  );

  pgwr_timer #(
    .WRITE_CYCLES(WRITE_CYCLES), .PAGE_BYTES(PAGE_BYTES)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .go          (commit_go),
    .busy        (busy),
    .done        (cycle_done),
    .scan_active (scan_active),
    .scan_idx    (scan_idx)
  );

  // Write port registered in step with the latch's registered read.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_we   <= scan_active && valid_vec[scan_idx];
      mem_addr <= {page, scan_idx};
    end
  end

  // R4: array writes only happen inside a write cycle
  p_we_in_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R5: an unqualified STOP never opens a write cycle
  p_bad_stop_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (stop_stb && !stop_ok && !busy) |=> !busy);

  // R6: a protected target leaves the block idle
  p_wp_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (stop_stb && !busy && wp && (page[PAGE_W-1 -: 2] == 2'b11)) |=> !busy);

  // R9: the latched page cannot move during a write cycle
  p_page_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(page));
endmodule

// File: tb/tb_pgwr_commit.sv
module tb_pgwr_commit;
  localparam int WC = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_stb = 0, addr_load = 0, byte_stb = 0, stop_stb = 0, stop_ok = 0, wp = 0;
  logic [12:0] addr_in = '0;
  logic [7:0]  byte_data = '0;
  logic        busy, mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0, failures = 0;
  int wr_n = 0;
  logic [12:0] wa [64];
  logic [7:0]  wd [64];

  always #2 clk = ~clk;  // 250 MHz

  pgwr_commit #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst(rst), .start_stb(start_stb), .addr_load(addr_load),
    .addr_in(addr_in), .byte_stb(byte_stb), .byte_data(byte_data),
    .stop_stb(stop_stb), .stop_ok(stop_ok), .wp(wp), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(negedge clk) begin
    if (mem_we && wr_n < 64) begin
      wa[wr_n] = mem_addr;
      wd[wr_n] = mem_wdata;
    end
    if (mem_we) wr_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic p_start();
    start_stb = 1; @(negedge clk); start_stb = 0;
  endtask
  task automatic p_addr(input logic [12:0] a);
    addr_in = a; addr_load = 1; @(negedge clk); addr_load = 0;
  endtask
  task automatic p_byte(input logic [7:0] d);
    byte_data = d; byte_stb = 1; @(negedge clk); byte_stb = 0;
  endtask
  // Issue a STOP, then count busy clocks over a window longer than a cycle.
  task automatic p_stop(input logic ok, output int bc);
    stop_ok = ok; stop_stb = 1; @(negedge clk); stop_stb = 0; stop_ok = 0;
    bc = 0;
    if (busy) bc++;
    repeat (WC + 40) begin @(negedge clk); if (busy) bc++; end
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(mem_we == 0, "R1 mem_we after reset", mem_we, 0);
    rst = 0; @(negedge clk);
  endtask

  task automatic t_byte_write();
    int bc;
    wr_n = 0;
    p_start(); p_addr(13'h0123); p_byte(8'hA5); p_stop(1, bc);
    chk(bc == WC, "R8 busy length", bc, WC);
    chk(wr_n == 1, "R4 single byte write count", wr_n, 1);
    chk(wa[0] == 13'h0123, "R2 byte write address", wa[0], 13'h0123);
    chk(wd[0] == 8'hA5, "R4 byte write data", wd[0], 8'hA5);
  endtask

  task automatic t_partial_page();
    int bc;
    wr_n = 0;
    p_start(); p_addr(13'h0045);
    for (int i = 0; i < 3; i++) p_byte(8'h10 + 8'(i));
    p_stop(1, bc);
    chk(wr_n == 3, "R4 partial page count", wr_n, 3);
    for (int i = 0; i < 3; i++) begin
      chk(wa[i] == 13'h0045 + 13'(i), "R2 address advance", wa[i], 13'h0045 + i);
      chk(wd[i] == 8'h10 + 8'(i), "R2 data order", wd[i], 8'h10 + i);
    end
  endtask

  task automatic t_wrap();
    int bc;
    logic [12:0] ea [4] = '{13'h0020, 13'h0021, 13'h003E, 13'h003F};
    logic [7:0]  ed [4] = '{8'hD2, 8'hD3, 8'hD0, 8'hD1};
    wr_n = 0;
    p_start(); p_addr(13'h003E);
    for (int i = 0; i < 4; i++) p_byte(8'hD0 + 8'(i));
    p_stop(1, bc);
    chk(wr_n == 4, "R3 wrap write count", wr_n, 4);
    for (int i = 0; i < 4; i++) begin
      chk(wa[i] == ea[i], "R3 wrapped address ascending", wa[i], ea[i]);
      chk(wd[i] == ed[i], "R3 wrapped data", wd[i], ed[i]);
    end
    wr_n = 0;
    p_start(); p_addr(13'h0400);
    for (int i = 0; i < 33; i++) p_byte(8'h40 + 8'(i));
    p_stop(1, bc);
    chk(wr_n == 32, "R3 full page count", wr_n, 32);
    chk(wd[0] == 8'h60, "R3 33rd byte overwrites column 0", wd[0], 8'h60);
    chk(wd[31] == 8'h5F, "R3 column 31 data", wd[31], 8'h5F);
  endtask

  task automatic t_bad_stop();
    int bc;
    wr_n = 0;
    p_start(); p_addr(13'h0200); p_byte(8'h33); p_stop(0, bc);
    chk(bc == 0, "R5 unqualified stop busy", bc, 0);
    p_stop(1, bc);
    chk(bc == 0, "R5 discarded bytes not committed", bc, 0);
    chk(wr_n == 0, "R5 no writes", wr_n, 0);
  endtask

  task automatic t_start_clears();
    int bc;
    wr_n = 0;
    p_start(); p_addr(13'h0300); p_byte(8'h44); p_start(); p_stop(1, bc);
    chk(bc == 0, "R10 start clears latch", bc, 0);
    p_start(); p_addr(13'h0310); p_stop(1, bc);
    chk(bc == 0, "R10 dummy write no cycle", bc, 0);
    chk(wr_n == 0, "R10 no writes", wr_n, 0);
  endtask

  task automatic t_protect();
    int bc;
    wr_n = 0; wp = 1;
    p_start(); p_addr(13'h1800); p_byte(8'h55); p_byte(8'h56); p_stop(1, bc);
    chk(bc == 0, "R6 protected 0x1800 busy", bc, 0);
    p_start(); p_addr(13'h1FFF); p_byte(8'h57); p_stop(1, bc);
    chk(bc == 0, "R6 protected 0x1FFF busy", bc, 0);
    chk(wr_n == 0, "R6 protected writes", wr_n, 0);
    p_start(); p_addr(13'h17FF); p_byte(8'h58); p_stop(1, bc);
    chk(bc == WC, "R6 0x17FF still writable", bc, WC);
    chk(wr_n == 1 && wa[0] == 13'h17FF, "R6 0x17FF write address", wa[0], 13'h17FF);
    wp = 0;
  endtask

  task automatic t_unprotected();
    int bc;
    wr_n = 0; wp = 0;
    p_start(); p_addr(13'h1FFE); p_byte(8'h61); p_byte(8'h62); p_stop(1, bc);
    chk(bc == WC, "R7 upper quarter commit", bc, WC);
    chk(wr_n == 2, "R7 write count", wr_n, 2);
    chk(wa[1] == 13'h1FFF && wd[1] == 8'h62, "R7 last address data", wa[1], 13'h1FFF);
  endtask

  task automatic t_busy_ignore();
    int bc = 0;
    wr_n = 0;
    p_start(); p_addr(13'h0500); p_byte(8'h77);
    stop_ok = 1; stop_stb = 1; @(negedge clk);
    // Hold every strobe while busy, including its final clock.
    addr_in = 13'h0000; byte_data = 8'hEE;
    while (busy) begin
      addr_load = 1; byte_stb = 1; stop_stb = 1; stop_ok = 1; start_stb = 0;
      bc++;
      @(negedge clk);
      if (bc > WC + 5) break;
    end
    addr_load = 0; byte_stb = 0; stop_stb = 0; stop_ok = 0;
    chk(bc == WC, "R8 busy length under strobes", bc, WC);
    bc = 0;
    repeat (WC + 40) begin @(negedge clk); if (busy) bc++; end
    chk(bc == 0, "R9 strobes during busy ignored", bc, 0);
    chk(wr_n == 1, "R9 write count", wr_n, 1);
    chk(wd[0] == 8'h77, "R9 data untouched", wd[0], 8'h77);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_partial_page();
    t_wrap();
    t_bad_stop();
    t_start_clears();
    t_protect();
    t_unprotected();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule